// File: doc/BRIEF.md
# Ceiling Speed Supervisor

This block supervises a train's estimated speed against the current ceiling speed limit. Every clock cycle it derives three margins above the limit from the limit itself: a warning margin, a service-intervention margin and an emergency-intervention margin. It then places the speed into a band and advances a five-state supervision machine. The state drives two registered codes. One is a status code for the driver display. The other is a brake command for the train interface.

Speeds and limits are unsigned integers in units of 0.1 km/h. A limit of 110 km/h is therefore the value 1100. Up to and including that limit the three margins are fixed. Above it they grow linearly with the limit until each reaches its cap, and the block rounds down to whole 0.1 km/h steps.

A sudden change of speed is resolved within the same update: the block goes straight to the deepest state whose condition holds. Once emergency braking is entered, it is kept until the train stands still, or until revocation is permitted and the speed has fallen back to the limit. A configuration bit says whether a service brake is fitted. The block captures it while reset is held. An enable input hands supervision to another mode; while it is low the block rests in its normal state.

Top module: `csm_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `disp_code` and `brake_code` are both 0 (normal state), whatever the speed inputs carry.
- R2: For `speed_limit` ≤ 1100 the warning, service and emergency margins are 40, 55 and 75 (0.1 km/h units).
- R3: For `speed_limit` > 1100 the margins are floor((L+100)/30) capped at 50, floor((9L+1100)/200) capped at 100, and floor((3L−300)/40) capped at 150, where L is the limit.
- R4: From the normal state the block enters overspeed when speed > L, warning when speed > L + warning margin, service intervention when speed > L + service margin, and emergency intervention when speed > L + emergency margin. All comparisons are strict, and a jump lands directly in the deepest state whose condition holds.
- R5: In service intervention `brake_code` is 1 when `sb_fitted` was 1 during reset, and 2 when it was 0. Changes of `sb_fitted` after reset have no effect.
- R6: Overspeed, warning and service intervention return to normal when speed ≤ L. Warning and service intervention stay where they are while speed is above L but not above their own entry threshold.
- R7: Emergency intervention returns to normal only when speed = 0, or when `revoke_ok` = 1 and speed ≤ L. Otherwise it holds, including when `revoke_ok` = 1 with speed > L.
- R8: `disp_code` is 0 in normal, 2 in overspeed, 3 in warning and 4 in either intervention state. `brake_code` is 0 for released, 1 for service brake and 2 for emergency brake.
- R9: While `enable` = 0 the block is forced to normal with both codes at 0, whatever the speed and limit.
- R10: Both codes are registered. A change at the inputs shows at the outputs after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures `sb_fitted` |
| enable | input | 1 | 1 = ceiling supervision active |
| sb_fitted | input | 1 | 1 = service brake fitted (sampled during reset) |
| revoke_ok | input | 1 | 1 = emergency brake may be released once speed ≤ limit |
| speed_est | input | 12 | Estimated speed, 0.1 km/h units |
| speed_limit | input | 12 | Ceiling speed limit, 0.1 km/h units |
| disp_code | output | 3 | Display status code (0, 2, 3, 4) |
| brake_code | output | 2 | Brake command (0 released, 1 service, 2 emergency) |

## Verification
Two things can happen in one cycle. The speed can cross several thresholds at once, and the state machine's release rule for the current state can apply at the same time. The bench provokes this in two ways. It jumps the speed from the normal band straight past the emergency threshold. It also lowers the speed from emergency to a value that is above zero and at or below the limit, once with revocation off and once with it on. The result is judged after one edge: the deepest state must appear with no intermediate code, and the emergency state must hold or release exactly as the revocation rule requires. The threshold vectors sit one step either side of each margin, at limits below, at and above the 1100 break point, and where the caps apply.

// File: rtl/csm_pkg.sv
package csm_pkg;

    localparam int unsigned BREAK_LIMIT = 1100;  // 110 km/h in 0.1 km/h units
    localparam int unsigned MAR_W       = 8;     // margin width, holds up to 150

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_OVER   = 3'd1,
        ST_WARN   = 3'd2,
        ST_SBI    = 3'd3,
        ST_EBI    = 3'd4
    } sup_state_e;

    typedef enum logic [2:0] {
        BAND_OK   = 3'd0,
        BAND_OVER = 3'd1,
        BAND_WARN = 3'd2,
        BAND_SBI  = 3'd3,
        BAND_EBI  = 3'd4
    } speed_band_e;

    typedef struct packed {
        logic [MAR_W-1:0] warn;
        logic [MAR_W-1:0] sbi;
        logic [MAR_W-1:0] ebi;
    } margins_t;

    typedef struct packed {
        logic [2:0] disp;
        logic [1:0] brake;
    } codes_t;

    function automatic int unsigned warn_margin(int unsigned lim);
        int unsigned m;
        if (lim <= BREAK_LIMIT) return 40;
        m = (lim + 100) / 30;
        return (m > 50) ? 50 : m;
    endfunction

    function automatic int unsigned sbi_margin(int unsigned lim);
        int unsigned m;
        if (lim <= BREAK_LIMIT) return 55;
        m = (9 * lim + 1100) / 200;
        return (m > 100) ? 100 : m;
    endfunction

    function automatic int unsigned ebi_margin(int unsigned lim);
        int unsigned m;
        if (lim <= BREAK_LIMIT) return 75;
        m = (3 * lim - 300) / 40;
        return (m > 150) ? 150 : m;
    endfunction

    function automatic codes_t state_codes(sup_state_e st, logic fitted);
        codes_t c;
        c = '0;
        unique case (st)
            ST_NORMAL: c = '{disp: 3'd0, brake: 2'd0};
            ST_OVER:   c = '{disp: 3'd2, brake: 2'd0};
            ST_WARN:   c = '{disp: 3'd3, brake: 2'd0};
            ST_SBI:    c = '{disp: 3'd4, brake: fitted ? 2'd1 : 2'd2};
            ST_EBI:    c = '{disp: 3'd4, brake: 2'd2};
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/csm_margins.sv
module csm_margins
    import csm_pkg::*;
#(
    parameter int unsigned SPD_W = 12
) (
    input  logic [SPD_W-1:0] limit,
    output margins_t         mar
);
    always_comb begin
        mar.warn = MAR_W'(warn_margin(32'(limit)));
        mar.sbi  = MAR_W'(sbi_margin(32'(limit)));
        mar.ebi  = MAR_W'(ebi_margin(32'(limit)));
    end

    // R2/R3: margins are strictly ordered and within their caps
    always_comb begin
        p_margin_order_r3: assert (mar.warn < mar.sbi && mar.sbi < mar.ebi);
        p_margin_cap_r3:   assert (mar.warn <= 50 && mar.sbi <= 100 && mar.ebi <= 150);
    end
endmodule

// File: rtl/csm_classify.sv
module csm_classify
    import csm_pkg::*;
#(
    parameter int unsigned SPD_W = 12
) (
    input  logic [SPD_W-1:0] speed,
    input  logic [SPD_W-1:0] limit,
    input  margins_t         mar,
    output speed_band_e      band,
    output logic             standstill
);
    localparam int unsigned SUM_W = SPD_W + 1;

    logic [SUM_W-1:0] spd_x, lim_x, thr_warn, thr_sbi, thr_ebi;

    always_comb begin
        spd_x    = SUM_W'(speed);
        lim_x    = SUM_W'(limit);
        thr_warn = lim_x + SUM_W'(mar.warn);
        thr_sbi  = lim_x + SUM_W'(mar.sbi);
        thr_ebi  = lim_x + SUM_W'(mar.ebi);
        standstill = (speed == '0);
        if (spd_x > thr_ebi)       band = BAND_EBI;
        else if (spd_x > thr_sbi)  band = BAND_SBI;
        else if (spd_x > thr_warn) band = BAND_WARN;
        else if (spd_x > lim_x)    band = BAND_OVER;
        else                       band = BAND_OK;
    end
endmodule

// File: rtl/csm_fsm.sv
module csm_fsm
    import csm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        sb_fitted,
    input  logic        revoke_ok,
    input  speed_band_e band,
    input  logic        standstill,
    output codes_t      codes_q
);
    sup_state_e state_q, state_d;
    logic       fitted_q;

    // Settle to the final stable state within one update
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_NORMAL;
        end else begin
            unique case (state_q)
                ST_NORMAL, ST_OVER: begin
                    unique case (band)
                        BAND_EBI:  state_d = ST_EBI;
                        BAND_SBI:  state_d = ST_SBI;
                        BAND_WARN: state_d = ST_WARN;
                        BAND_OVER: state_d = ST_OVER;
                        default:   state_d = ST_NORMAL;
                    endcase
                end
                ST_WARN: begin
                    unique case (band)
                        BAND_EBI: state_d = ST_EBI;
                        BAND_SBI: state_d = ST_SBI;
                        BAND_OK:  state_d = ST_NORMAL;
                        default:  state_d = ST_WARN;
                    endcase
                end
                ST_SBI: begin
                    unique case (band)
                        BAND_EBI: state_d = ST_EBI;
                        BAND_OK:  state_d = ST_NORMAL;
                        default:  state_d = ST_SBI;
                    endcase
                end
                ST_EBI: begin
                    if (standstill || (revoke_ok && band == BAND_OK))
                        state_d = ST_NORMAL;
                    else
                        state_d = ST_EBI;
                end
                default: state_d = ST_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_NORMAL;
            fitted_q <= sb_fitted;
            codes_q  <= '0;
        end else begin
            state_q  <= state_d;
            codes_q  <= state_codes(state_d, fitted_q);
        end
    end

    // R9: a disabled cycle leaves both codes cleared
    p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (codes_q.disp == 3'd0 && codes_q.brake == 2'd0));

    // R4: a jump past the emergency threshold lands in emergency directly
    p_deep_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (enable && band == BAND_EBI) |=> (state_q == ST_EBI && codes_q.brake == 2'd2));

    // R7: emergency holds unless standstill or permitted revocation
    p_eb_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && state_q == ST_EBI && !standstill && !(revoke_ok && band == BAND_OK))
        |=> (state_q == ST_EBI));

    // R6: non-emergency states fall back once speed is at or below the limit
    p_fall_back_r6: assert property (@(posedge clk) disable iff (rst)
        (enable && state_q != ST_EBI && band == BAND_OK) |=> (state_q == ST_NORMAL));

    // R8: any brake command comes with the intervention display code
    p_brake_display_r8: assert property (@(posedge clk) disable iff (rst)
        (codes_q.brake != 2'd0) |-> (codes_q.disp == 3'd4));

    // R5: the captured fitted bit never moves outside reset
    p_fitted_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(fitted_q));
endmodule

// File: rtl/csm_supervisor.sv
module csm_supervisor
    import csm_pkg::*;
#(
    parameter int unsigned SPD_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             sb_fitted,
    input  logic             revoke_ok,
    input  logic [SPD_W-1:0] speed_est,
    input  logic [SPD_W-1:0] speed_limit,
    output logic [2:0]       disp_code,
    output logic [1:0]       brake_code
);
    margins_t    mar;
    speed_band_e band;
    logic        standstill;
    codes_t      codes_q;

    csm_margins #(.SPD_W(SPD_W)) u_margins (
        .limit (speed_limit),
        .mar   (mar)
    );

    csm_classify #(.SPD_W(SPD_W)) u_classify (
        .speed      (speed_est),
        .limit      (speed_limit),
        .mar        (mar),
        .band       (band),
        .standstill (standstill)
    );

    csm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .sb_fitted  (sb_fitted),
        .revoke_ok  (revoke_ok),
        .band       (band),
        .standstill (standstill),
        .codes_q    (codes_q)
    );

    assign disp_code  = codes_q.disp;
    assign brake_code = codes_q.brake;

    // R1: the cycle after reset shows the normal state
    p_reset_normal_r1: assert property (@(posedge clk)
        $fell(rst) |-> (disp_code == 3'd0 && brake_code == 2'd0));
endmodule

// File: tb/test_csm_supervisor.sv
module test_csm_supervisor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b1;
    logic        sb_fitted = 1'b1;
    logic        revoke_ok = 1'b0;
    logic [11:0] speed_est = '0;
    logic [11:0] speed_limit = 12'd900;
    logic [2:0]  disp_code;
    logic [1:0]  brake_code;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    csm_supervisor i_csm_supervisor (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .sb_fitted   (sb_fitted),
        .revoke_ok   (revoke_ok),
        .speed_est   (speed_est),
        .speed_limit (speed_limit),
        .disp_code   (disp_code),
        .brake_code  (brake_code)
    );

    typedef struct packed {
        logic        en;
        logic        rev;
        logic [11:0] sp;
        logic [11:0] lim;
        logic [2:0]  disp;
        logic [1:0]  brk;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 48;
    // Applied in sequence from normal state, service brake fitted.
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,12'd600, 12'd900, 3'd0,2'd0,4'd8},  // R8 normal
        '{1'b1,1'b0,12'd901, 12'd900, 3'd2,2'd0,4'd4},  // R4 just over
        '{1'b1,1'b0,12'd940, 12'd900, 3'd2,2'd0,4'd4},  // R4 warn strict
        '{1'b1,1'b0,12'd941, 12'd900, 3'd3,2'd0,4'd4},
        '{1'b1,1'b0,12'd920, 12'd900, 3'd3,2'd0,4'd6},  // R6 warn holds
        '{1'b1,1'b0,12'd955, 12'd900, 3'd3,2'd0,4'd6},
        '{1'b1,1'b0,12'd956, 12'd900, 3'd4,2'd1,4'd5},  // R5 service brake
        '{1'b1,1'b0,12'd930, 12'd900, 3'd4,2'd1,4'd6},  // R6 service holds
        '{1'b1,1'b0,12'd900, 12'd900, 3'd0,2'd0,4'd6},
        '{1'b1,1'b0,12'd976, 12'd900, 3'd4,2'd2,4'd4},  // R4 jump to emergency
        '{1'b1,1'b0,12'd975, 12'd900, 3'd4,2'd2,4'd7},
        '{1'b1,1'b0,12'd500, 12'd900, 3'd4,2'd2,4'd7},  // R7 no revoke
        '{1'b1,1'b1,12'd500, 12'd900, 3'd0,2'd0,4'd7},  // R7 revoke
        '{1'b1,1'b0,12'd960, 12'd900, 3'd4,2'd1,4'd4},  // R4 jump to service
        '{1'b1,1'b0,12'd975, 12'd900, 3'd4,2'd1,4'd6},
        '{1'b1,1'b0,12'd976, 12'd900, 3'd4,2'd2,4'd4},
        '{1'b1,1'b1,12'd800, 12'd900, 3'd0,2'd0,4'd7},
        '{1'b1,1'b0,12'd1140,12'd1100,3'd2,2'd0,4'd2},  // R2 at break point
        '{1'b1,1'b0,12'd1141,12'd1100,3'd3,2'd0,4'd2},
        '{1'b1,1'b0,12'd1155,12'd1100,3'd3,2'd0,4'd2},
        '{1'b1,1'b0,12'd1156,12'd1100,3'd4,2'd1,4'd2},
        '{1'b1,1'b0,12'd1175,12'd1100,3'd4,2'd1,4'd2},
        '{1'b1,1'b0,12'd1176,12'd1100,3'd4,2'd2,4'd2},
        '{1'b1,1'b0,12'd0,   12'd1100,3'd0,2'd0,4'd7},  // R7 standstill
        '{1'b1,1'b0,12'd1243,12'd1200,3'd2,2'd0,4'd3},  // R3 margins 43/59/82
        '{1'b1,1'b0,12'd1244,12'd1200,3'd3,2'd0,4'd3},
        '{1'b1,1'b0,12'd1259,12'd1200,3'd3,2'd0,4'd3},
        '{1'b1,1'b0,12'd1260,12'd1200,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd1282,12'd1200,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd1283,12'd1200,3'd4,2'd2,4'd3},
        '{1'b1,1'b1,12'd1200,12'd1200,3'd0,2'd0,4'd7},
        '{1'b1,1'b0,12'd1550,12'd1500,3'd2,2'd0,4'd3},  // R3 margins 50/73/105
        '{1'b1,1'b0,12'd1551,12'd1500,3'd3,2'd0,4'd3},
        '{1'b1,1'b0,12'd1573,12'd1500,3'd3,2'd0,4'd3},
        '{1'b1,1'b0,12'd1574,12'd1500,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd1605,12'd1500,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd1606,12'd1500,3'd4,2'd2,4'd3},
        '{1'b1,1'b1,12'd1501,12'd1500,3'd4,2'd2,4'd7},  // R7 revoke, still over
        '{1'b1,1'b0,12'd0,   12'd1500,3'd0,2'd0,4'd7},
        '{1'b1,1'b0,12'd3950,12'd3900,3'd2,2'd0,4'd3},  // R3 caps 50/100/150
        '{1'b1,1'b0,12'd3951,12'd3900,3'd3,2'd0,4'd3},
        '{1'b1,1'b0,12'd4001,12'd3900,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd4050,12'd3900,3'd4,2'd1,4'd3},
        '{1'b1,1'b0,12'd4051,12'd3900,3'd4,2'd2,4'd3},
        '{1'b1,1'b0,12'd0,   12'd3900,3'd0,2'd0,4'd7},
        '{1'b1,1'b0,12'd901, 12'd900, 3'd2,2'd0,4'd6},  // R6 overspeed returns
        '{1'b1,1'b0,12'd900, 12'd900, 3'd0,2'd0,4'd6},
        '{1'b1,1'b0,12'd941, 12'd900, 3'd3,2'd0,4'd6}
    };

    task automatic check(string tag, logic [2:0] exp_disp, logic [1:0] exp_brk);
        n_checks++;
        if (disp_code !== exp_disp || brake_code !== exp_brk) begin
            n_fail++;
            $display("FAIL %s: got disp=%0d brake=%0d, expected disp=%0d brake=%0d",
                     tag, disp_code, brake_code, exp_disp, exp_brk);
        end
    endtask

    task automatic drive(logic en, logic rev, logic [11:0] sp, logic [11:0] lim);
        enable      = en;
        revoke_ok   = rev;
        speed_est   = sp;
        speed_limit = lim;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R1: reset state with a speed far above the limit
        drive(1'b1, 1'b0, 12'd3000, 12'd900);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 during reset", 3'd0, 2'd0);
        drive(1'b1, 1'b0, 12'd600, 12'd900);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 3'd0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].en, VEC[i].rev, VEC[i].sp, VEC[i].lim);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].disp, VEC[i].brk);
        end

        // R9: disable while in warning, with emergency-level speed
        drive(1'b0, 1'b0, 12'd4000, 12'd900);
        @(negedge clk);
        check("R9 disabled forces normal", 3'd0, 2'd0);
        @(negedge clk);
        check("R9 speed ignored while disabled", 3'd0, 2'd0);
        drive(1'b1, 1'b0, 12'd4000, 12'd900);
        @(negedge clk);
        check("R4 enable with jump to emergency", 3'd4, 2'd2);
        drive(1'b0, 1'b0, 12'd4000, 12'd900);
        @(negedge clk);
        check("R9 disable leaves emergency", 3'd0, 2'd0);

        // R10: no change before the edge, change after it
        drive(1'b1, 1'b0, 12'd941, 12'd900);
        #1;
        check("R10 before edge", 3'd0, 2'd0);
        @(negedge clk);
        check("R10 after edge", 3'd3, 2'd0);

        // R5: service brake not fitted at reset, bit raised afterwards
        rst = 1'b1;
        sb_fitted = 1'b0;
        drive(1'b1, 1'b0, 12'd600, 12'd900);
        @(negedge clk);
        @(negedge clk);
        check("R1 second reset", 3'd0, 2'd0);
        rst = 1'b0;
        sb_fitted = 1'b1;
        drive(1'b1, 1'b0, 12'd956, 12'd900);
        @(negedge clk);
        check("R5 unfitted uses emergency brake", 3'd4, 2'd2);
        drive(1'b1, 1'b0, 12'd930, 12'd900);
        @(negedge clk);
        check("R5 unfitted service state holds", 3'd4, 2'd2);
        drive(1'b1, 1'b0, 12'd500, 12'd900);
        @(negedge clk);
        check("R6 unfitted service returns", 3'd0, 2'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule